// File: doc/BRIEF.md
# Cache Tag Store with Comparator

This block is the tag directory of an external secondary cache. Each entry holds a tag and three status flags (valid, dirty, write-through). The processor address picks an entry. The stored tag and flags are read without a clock, and the stored tag is compared with the tag presented on the input. The result comes out on an active-high `match` output, which a cache controller uses to start or skip a secondary access.

Tag writes and flag writes happen on the rising clock edge and have separate enables. Each field also has its own output enable. While a write is in progress, the value being written is shown on the outputs. A function-select input chooses how the flags are used:
- In dedicated mode, a clear valid flag suppresses `match`.
- In generic mode, the flags are plain storage and `match` depends on the tag alone.

A synchronous active-low reset clears the flags of every entry in one cycle. It leaves the tags alone. Pad drivers are modelled as a data output plus an enable.

Top module: `tag_store`

## Requirements
- R1: The block is selected only when `cs_a_n` is 0 and `cs_b` is 1. When it is not selected, `tag_out_en`, `stat_out_en` and `match_en` are 0 and rising edges write nothing. When it is selected, `match_en` is 1.
- R2: When the block is selected, `rst_n` is 1 and `tag_we_n` is 0 at a rising edge, `tag_in` is stored at entry `addr`. `tag_out` shows the stored tag of entry `addr` combinationally.
- R3: A rising edge with `stat_we_n` at 0 stores `valid_in`, `dirty_in` and `wthru_in` at entry `addr` and leaves the tag alone. A tag write leaves the flags alone. With both enables at 0, both fields of the same entry are written.
- R4: `tag_out_en` is 1 exactly when the block is selected, `tag_oe_n` is 0 and `rst_n` is 1. `stat_out_en` is 1 exactly when the block is selected and `stat_oe_n` is 0.
- R5: While `tag_we_n` is 0, `tag_out` equals `tag_in`. While `stat_we_n` is 0, the three flag outputs equal the three flag inputs.
- R6: When `generic_mode` is 1 and `rst_n` is 1, `match` is 1 exactly when `tag_in` equals the stored tag of entry `addr`, whatever the flags hold.
- R7: When `generic_mode` is 0 and `rst_n` is 1, `match` is 1 exactly when the tags are equal and the stored valid flag of the entry is 1.
- R8: When `rst_n` is 0 at a rising edge, the valid, dirty and write-through flags of every entry become 0. The tags of all entries keep their values.
- R9: While `rst_n` is 0, `tag_out_en` and `match` are 0.
- R10: A write enable that is 0 at the same rising edge as `rst_n` at 0 has no effect. The reset wins, and the tag is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write and reset clock |
| rst_n | input | 1 | Synchronous active-low flag clear |
| cs_a_n | input | 1 | Active-low chip select |
| cs_b | input | 1 | Active-high chip select |
| addr | input | ADDR_W | Entry index |
| tag_in | input | TAG_W | Tag to compare or write |
| valid_in | input | 1 | Valid flag to write |
| dirty_in | input | 1 | Dirty flag to write |
| wthru_in | input | 1 | Write-through flag to write |
| tag_we_n | input | 1 | Active-low tag write enable |
| stat_we_n | input | 1 | Active-low flag write enable |
| tag_oe_n | input | 1 | Active-low tag output enable |
| stat_oe_n | input | 1 | Active-low flag output enable |
| generic_mode | input | 1 | 1: flags are generic and `match` ignores them; 0: flags have their dedicated meaning |
| tag_out | output | TAG_W | Tag read data |
| tag_out_en | output | 1 | Drive enable for the tag pads |
| valid_out | output | 1 | Valid flag read data |
| dirty_out | output | 1 | Dirty flag read data |
| wthru_out | output | 1 | Write-through flag read data |
| stat_out_en | output | 1 | Drive enable for the flag pads |
| match | output | 1 | Tag hit indication |
| match_en | output | 1 | Drive enable for the hit pad |

## Verification
The bench builds the block with `TAG_W` = 4 and `DEPTH` = 16. With this configuration every pairing of entry and input tag can be compared in both function-select modes, so the whole comparator truth table is covered for each stored pattern. The small array also lets the bench read back every entry after each reset, to confirm that all flags were cleared and no tag was disturbed.

// File: rtl/tag_store.sv
module tag_store #(
  parameter int TAG_W = 12,
  parameter int DEPTH = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic              valid_in,
  input  logic              dirty_in,
  input  logic              wthru_in,
  input  logic              tag_we_n,
  input  logic              stat_we_n,
  input  logic              tag_oe_n,
  input  logic              stat_oe_n,
  input  logic              generic_mode,
  output logic [TAG_W-1:0]  tag_out,
  output logic              tag_out_en,
  output logic              valid_out,
  output logic              dirty_out,
  output logic              wthru_out,
  output logic              stat_out_en,
  output logic              match,
  output logic              match_en
);

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] vld_q, dty_q, wt_q;
  logic             sel, tag_wr, stat_wr;
  logic [TAG_W-1:0] tag_rd;

  assign sel     = !cs_a_n && cs_b;
  assign tag_wr  = sel && !tag_we_n && rst_n;
  assign stat_wr = sel && !stat_we_n && rst_n;
  assign tag_rd  = tag_mem[addr];

  always_ff @(posedge clk)
    if (tag_wr) tag_mem[addr] <= tag_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
      wt_q  <= '0;
    end else if (stat_wr) begin
      vld_q[addr] <= valid_in;
      dty_q[addr] <= dirty_in;
      wt_q[addr]  <= wthru_in;
    end
  end

  assign tag_out     = !tag_we_n  ? tag_in   : tag_rd;
  assign valid_out   = !stat_we_n ? valid_in : vld_q[addr];
  assign dirty_out   = !stat_we_n ? dirty_in : dty_q[addr];
  assign wthru_out   = !stat_we_n ? wthru_in : wt_q[addr];

  assign tag_out_en  = sel && !tag_oe_n && rst_n;
  assign stat_out_en = sel && !stat_oe_n;
  assign match_en    = sel;
  assign match       = rst_n && (tag_in == tag_rd) && (generic_mode || vld_q[addr]);

endmodule

// File: rtl/tag_store_chk.sv
module tag_store_chk #(
  parameter int TAG_W = 12,
  parameter int DEPTH = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_a_n,
  input logic              cs_b,
  input logic [ADDR_W-1:0] addr,
  input logic [TAG_W-1:0]  tag_in,
  input logic              tag_we_n,
  input logic              stat_we_n,
  input logic              generic_mode,
  input logic [TAG_W-1:0]  tag_out,
  input logic              tag_out_en,
  input logic              valid_out,
  input logic              dirty_out,
  input logic              wthru_out,
  input logic              stat_out_en,
  input logic              match,
  input logic              match_en
);

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_a_n && cs_b) |-> (!tag_out_en && !stat_out_en && !match_en));

  assert_tag_persists_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_a_n && cs_b && !tag_we_n) |=>
      (!tag_we_n || addr != $past(addr) || tag_out == $past(tag_in)));

  assert_match_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match && tag_we_n) |-> (tag_out == tag_in));

  assert_dedicated_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !generic_mode && stat_we_n) |-> valid_out);

  assert_flags_cleared_R8: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || !stat_we_n || {valid_out, dirty_out, wthru_out} == 3'b000));

  assert_reset_hides_R9: assert property (@(posedge clk)
    !rst_n |-> (!tag_out_en && !match));

endmodule

bind tag_store tag_store_chk #(.TAG_W(TAG_W), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .addr(addr),
  .tag_in(tag_in), .tag_we_n(tag_we_n), .stat_we_n(stat_we_n),
  .generic_mode(generic_mode), .tag_out(tag_out), .tag_out_en(tag_out_en),
  .valid_out(valid_out), .dirty_out(dirty_out), .wthru_out(wthru_out),
  .stat_out_en(stat_out_en), .match(match), .match_en(match_en)
);

// File: tb/test_tag_store.sv
module test_tag_store;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 4;
  localparam int DP = 16;
  localparam int AW = $clog2(DP);

  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_a_n = 1'b0, cs_b = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [TW-1:0] tag_in = '0;
  logic valid_in = 1'b0, dirty_in = 1'b0, wthru_in = 1'b0;
  logic tag_we_n = 1'b1, stat_we_n = 1'b1, tag_oe_n = 1'b0, stat_oe_n = 1'b0;
  logic generic_mode = 1'b0;
  logic [TW-1:0] tag_out;
  logic tag_out_en, valid_out, dirty_out, wthru_out, stat_out_en, match, match_en;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [TW-1:0] ref_tag [DP];
  logic [2:0]    ref_st  [DP];

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_store #(.TAG_W(TW), .DEPTH(DP)) i_tag_store (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .addr(addr),
    .tag_in(tag_in), .valid_in(valid_in), .dirty_in(dirty_in), .wthru_in(wthru_in),
    .tag_we_n(tag_we_n), .stat_we_n(stat_we_n), .tag_oe_n(tag_oe_n),
    .stat_oe_n(stat_oe_n), .generic_mode(generic_mode), .tag_out(tag_out),
    .tag_out_en(tag_out_en), .valid_out(valid_out), .dirty_out(dirty_out),
    .wthru_out(wthru_out), .stat_out_en(stat_out_en), .match(match), .match_en(match_en)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [TW-1:0] pat(input int a);
    return TW'((a * 7 + 3) % (1 << TW));
  endfunction

  task automatic edge_then_idle();
    @(posedge clk);
    @(negedge clk);
    tag_we_n = 1'b1; stat_we_n = 1'b1;
  endtask

  task automatic check_all_entries(input string req);
    for (int a = 0; a < DP; a++) begin
      addr = AW'(a); #1;
      chk(tag_out, ref_tag[a], req);
      chk({valid_out, dirty_out, wthru_out}, ref_st[a], req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(posedge clk); @(posedge clk);
    @(negedge clk); #1;
    // R9, R4: hidden outputs during reset
    chk(tag_out_en, 0, "R9 tag_out_en in reset");
    chk(match, 0, "R9 match in reset");
    chk(stat_out_en, 1, "R4 stat_out_en in reset");
    chk(match_en, 1, "R1 match_en selected");
    rst_n = 1'b1; #1;
    for (int a = 0; a < DP; a++) begin
      addr = AW'(a); #1;
      chk({valid_out, dirty_out, wthru_out}, 0, "R8 flags after reset");
    end
    chk(tag_out_en, 1, "R4 tag_out_en active");

    // R2, R3, R5: tag-only writes with flag inputs set
    for (int a = 0; a < DP; a++) begin
      addr = AW'(a); tag_in = pat(a); {valid_in, dirty_in, wthru_in} = 3'b111;
      tag_we_n = 1'b0; #1;
      chk(tag_out, pat(a), "R5 tag write-through");
      chk({valid_out, dirty_out, wthru_out}, 0, "R3 flags untouched during tag write");
      ref_tag[a] = pat(a); ref_st[a] = 3'b000;
      edge_then_idle();
    end
    check_all_entries("R2/R3 after tag writes");

    // R3, R5: flag-only writes with a different tag on the input
    for (int a = 0; a < DP; a++) begin
      addr = AW'(a); tag_in = ~pat(a);
      {valid_in, dirty_in, wthru_in} = 3'(a) ^ 3'b010;
      stat_we_n = 1'b0; #1;
      chk({valid_out, dirty_out, wthru_out}, 3'(a) ^ 3'b010, "R5 flag write-through");
      ref_st[a] = 3'(a) ^ 3'b010;
      edge_then_idle();
    end
    check_all_entries("R3 after flag writes");

    // R6, R7: full comparator sweep in both modes
    for (int m = 0; m < 2; m++) begin
      generic_mode = m[0];
      for (int a = 0; a < DP; a++)
        for (int t = 0; t < (1 << TW); t++) begin
          addr = AW'(a); tag_in = TW'(t); #1;
          chk(match, (TW'(t) == ref_tag[a]) && (m == 1 || ref_st[a][2]),
              m == 1 ? "R6 generic match" : "R7 dedicated match");
        end
    end

    // R4: output enables
    tag_oe_n = 1'b1; #1;
    chk(tag_out_en, 0, "R4 tag_oe_n high");
    chk(stat_out_en, 1, "R4 stat field still on");
    stat_oe_n = 1'b1; #1;
    chk(stat_out_en, 0, "R4 stat_oe_n high");
    tag_oe_n = 1'b0; stat_oe_n = 1'b0;

    // R1: deselect variants and ignored writes
    for (int v = 0; v < 3; v++) begin
      cs_a_n = (v != 1); cs_b = (v == 1) ? 1'b0 : (v == 2);
      #1;
      chk({tag_out_en, stat_out_en, match_en}, 0, "R1 deselected enables");
      addr = AW'(v); tag_in = ~ref_tag[v]; {valid_in, dirty_in, wthru_in} = ~ref_st[v];
      tag_we_n = 1'b0; stat_we_n = 1'b0;
      edge_then_idle();
    end
    cs_a_n = 1'b0; cs_b = 1'b1;
    check_all_entries("R1 writes ignored when deselected");

    // R3: both enables together
    addr = 5; tag_in = 4'hA; {valid_in, dirty_in, wthru_in} = 3'b101;
    tag_we_n = 1'b0; stat_we_n = 1'b0;
    ref_tag[5] = 4'hA; ref_st[5] = 3'b101;
    edge_then_idle();
    #1;
    chk(tag_out, 4'hA, "R3 joint tag write");
    chk({valid_out, dirty_out, wthru_out}, 3'b101, "R3 joint flag write");

    // R8, R10: reset with a colliding tag write
    addr = 3; tag_in = ~ref_tag[3]; rst_n = 1'b0; tag_we_n = 1'b0;
    edge_then_idle();
    rst_n = 1'b1;
    for (int a = 0; a < DP; a++) ref_st[a] = 3'b000;
    check_all_entries("R8/R10 after mid-run reset");
    generic_mode = 1'b0;
    for (int a = 0; a < DP; a++) begin
      addr = AW'(a); tag_in = ref_tag[a]; #1;
      chk(match, 0, "R7 invalid after reset");
    end
    generic_mode = 1'b1; addr = 3; tag_in = ref_tag[3]; #1;
    chk(match, 1, "R10 tag kept, generic match");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule